// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Wired Floor Replacement

This block is a 16-entry fully associative translation buffer for a 20-bit virtual page number space. Each entry holds a virtual page, a physical page, a cacheability attribute, an 8-bit address-space tag and a global flag. A lookup matches when the page agrees and either the tag equals the current address-space register or the entry is global. Translations for many processes can therefore stay resident together, and a context switch is only a write of the new tag into that register.

Software fills entries through a write port, either at an explicit index or at the index currently held by a victim counter. The victim counter steps down by one every clock. It wraps to the top index instead of going below a software-written wired floor, so the entries below the floor are never picked for replacement. The block can also invalidate every non-global entry of one tag at once, which lets a tag be reused.

In supervisor mode, two fixed 512 MB windows skip the table and map straight onto physical pages 0 to 512 MB: one window is cached and the other uncached. User-mode lookups into the upper half of the virtual space report an address error. Every lookup result is registered and appears one cycle after the request.

Top module: `tagged_tlb`

## Requirements
- R1: `rsp_valid` is high in the cycle after `lk_req` is high and low in the cycle after `lk_req` is low; while it is low, `rsp_hit`, `rsp_addr_err`, `rsp_ppn` and `rsp_cached` are 0.
- R2: A mapped lookup hits when a valid entry has `vpn == lk_vpn` and either its global flag is set or its tag equals the current address-space register. A hit returns that entry's `ppn` and `cached`, and the lowest matching index wins. A miss returns `rsp_hit=0`, `rsp_addr_err=0`, `rsp_ppn=0` and `rsp_cached=0`.
- R3: Writing `asid_wdata` with `asid_we` changes only the 8-bit current address-space register. Entries of other tags stay valid and hit again once their tag is made current.
- R4: An entry filled with `fill_global=1` hits under every current address-space value.
- R5: `fill_we` writes an entry at `fill_index` when `fill_use_random=0`, and at the value of `random_idx` in that same cycle when `fill_use_random=1`.
- R6: `random_idx` is 15 after reset and decrements by 1 every cycle. In the cycle after it equals the wired floor, it becomes 15. It is never below the floor.
- R7: `wired_we` loads the floor from `wired_wdata` and sets `random_idx` to 15 in the next cycle. With the floor at N, entries 0 to N-1 are never overwritten by random fills.
- R8: In supervisor mode (`lk_super=1`), a lookup with `lk_vpn[19:17]=3'b100` hits with `rsp_ppn={3'b000,lk_vpn[16:0]}` and `rsp_cached=1`, and one with `3'b101` does the same with `rsp_cached=0`. Table contents do not affect these results.
- R9: A user-mode lookup (`lk_super=0`) with `lk_vpn[19]=1` gives `rsp_addr_err=1` and `rsp_hit=0`. Supervisor lookups with `lk_vpn[19:18]=2'b11` go through the table.
- R10: `inv_req` clears every non-global entry whose tag equals `inv_asid`. Global entries and entries of other tags are kept.
- R11: A lookup sees the table and the address-space register as they were before any write in the same cycle. When a fill and an invalidation land in the same cycle, the filled entry is written and stays valid.
- R12: After reset all entries are invalid, the current address-space value is 0, the floor is 0 and `random_idx` is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_super | input | 1 | Lookup privilege: 1 supervisor, 0 user |
| lk_vpn | input | 20 | Virtual page number to translate |
| asid_we | input | 1 | Write current address-space register |
| asid_wdata | input | 8 | New current address-space value |
| wired_we | input | 1 | Write wired floor |
| wired_wdata | input | 4 | New wired floor |
| fill_we | input | 1 | Write one entry |
| fill_use_random | input | 1 | 1: write at random_idx, 0: at fill_index |
| fill_index | input | 4 | Explicit entry index |
| fill_vpn | input | 20 | Entry virtual page |
| fill_asid | input | 8 | Entry address-space tag |
| fill_global | input | 1 | Entry ignores the tag comparison |
| fill_ppn | input | 20 | Entry physical page |
| fill_cached | input | 1 | Entry cacheability |
| inv_req | input | 1 | Invalidate non-global entries of one tag |
| inv_asid | input | 8 | Tag to invalidate |
| random_idx | output | 4 | Current victim index |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation found or direct window |
| rsp_addr_err | output | 1 | User access to the supervisor region |
| rsp_ppn | output | 20 | Physical page number |
| rsp_cached | output | 1 | Cacheability of the result |

## Verification
A lookup and a write of the table or of the current address-space register can fall in the same cycle. The bench makes this happen on purpose: it looks up a page while filling that same page, and it looks up a page while switching the tag. Each such lookup must return the result from before the write, and the lookup in the next cycle must show the new state. A fill and a tag invalidation are also issued together, and the filled entry must come out still valid. Random traffic mixes all operations freely, and every response and every victim index is compared with a bench model that applies the old-state rule.

// File: rtl/ttlb_pkg.sv
package ttlb_pkg;
    localparam int VPN_W    = 20;
    localparam int PPN_W    = 20;
    localparam int ASID_W   = 8;
    localparam int ENTRIES  = 16;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int REGION_W = 3;
    localparam int WIN_W    = VPN_W - REGION_W;

    localparam logic [REGION_W-1:0] SEG_DIRECT_CACHED   = 3'b100;
    localparam logic [REGION_W-1:0] SEG_DIRECT_UNCACHED = 3'b101;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic              cached;
    } tlb_entry_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             addr_err;
        logic [PPN_W-1:0] ppn;
        logic             cached;
    } tlb_rsp_t;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim
    import ttlb_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wired_we,
    input  logic [IW-1:0] wired_wdata,
    output logic [IW-1:0] rnd_idx,
    output logic [IW-1:0] wired_idx
);
    localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

    typedef struct packed {
        logic [IW-1:0] wired;
        logic [IW-1:0] rnd;
    } vic_state_t;

    vic_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wired_we) begin
            st_d.wired = wired_wdata;
            st_d.rnd   = TOP_IDX;
        end else if (st_q.rnd <= st_q.wired) begin
            st_d.rnd = TOP_IDX;
        end else begin
            st_d.rnd = st_q.rnd - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wired <= '0;
            st_q.rnd   <= TOP_IDX;
        end else begin
            st_q <= st_d;
        end
    end

    assign rnd_idx   = st_q.rnd;
    assign wired_idx = st_q.wired;
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import ttlb_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic              inv_en,
    input  logic [ASID_W-1:0] inv_tag,
    input  logic [VPN_W-1:0]  cmp_vpn,
    input  logic [ASID_W-1:0] cmp_tag,
    output logic              hit,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic              hit_cached
);
    tlb_entry_t [N-1:0] ent_d, ent_q;
    logic       [N-1:0] match_vec;

    // one comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_vec[g] = ent_q[g].valid
                            && (ent_q[g].vpn == cmp_vpn)
                            && (ent_q[g].glob || (ent_q[g].asid == cmp_tag));
    end

    // lowest matching index wins
    always_comb begin
        hit        = |match_vec;
        hit_ppn    = '0;
        hit_cached = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_ppn    = ent_q[i].ppn;
                hit_cached = ent_q[i].cached;
            end
        end
    end

    // invalidation first, then the fill overrides its own slot
    always_comb begin
        ent_d = ent_q;
        if (inv_en) begin
            for (int i = 0; i < N; i++) begin
                if (!ent_q[i].glob && (ent_q[i].asid == inv_tag)) begin
                    ent_d[i].valid = 1'b0;
                end
            end
        end
        if (wr_en) begin
            ent_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end
endmodule

// File: rtl/tlb_region.sv
module tlb_region
    import ttlb_pkg::*;
(
    input  logic             super_mode,
    input  logic [VPN_W-1:0] vpn,
    output logic             bypass,
    output logic             bypass_cached,
    output logic [PPN_W-1:0] bypass_ppn,
    output logic             addr_err
);
    logic [REGION_W-1:0] seg;

    always_comb begin
        seg           = vpn[VPN_W-1 -: REGION_W];
        addr_err      = !super_mode && vpn[VPN_W-1];
        bypass        = super_mode && ((seg == SEG_DIRECT_CACHED) || (seg == SEG_DIRECT_UNCACHED));
        bypass_cached = (seg == SEG_DIRECT_CACHED);
        bypass_ppn    = PPN_W'(vpn[WIN_W-1:0]);
    end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
    import ttlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic              lk_super,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              asid_we,
    input  logic [ASID_W-1:0] asid_wdata,
    input  logic              wired_we,
    input  logic [IDX_W-1:0]  wired_wdata,
    input  logic              fill_we,
    input  logic              fill_use_random,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_cached,
    input  logic              inv_req,
    input  logic [ASID_W-1:0] inv_asid,
    output logic [IDX_W-1:0]  random_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_addr_err,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_cached
);
    typedef struct packed {
        logic [ASID_W-1:0] asid;
        tlb_rsp_t          rsp;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [IDX_W-1:0] wired_idx;
    logic [IDX_W-1:0] wr_idx;
    tlb_entry_t       wr_entry;
    logic             tbl_hit;
    logic [PPN_W-1:0] tbl_ppn;
    logic             tbl_cached;
    logic             seg_bypass;
    logic             seg_cached;
    logic [PPN_W-1:0] seg_ppn;
    logic             seg_err;

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .wired_we    (wired_we),
        .wired_wdata (wired_wdata),
        .rnd_idx     (random_idx),
        .wired_idx   (wired_idx)
    );

    always_comb begin
        wr_idx          = fill_use_random ? random_idx : fill_index;
        wr_entry.valid  = 1'b1;
        wr_entry.glob   = fill_global;
        wr_entry.asid   = fill_asid;
        wr_entry.vpn    = fill_vpn;
        wr_entry.ppn    = fill_ppn;
        wr_entry.cached = fill_cached;
    end

    tlb_entry_array #(.N(ENTRIES)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fill_we),
        .wr_idx     (wr_idx),
        .wr_entry   (wr_entry),
        .inv_en     (inv_req),
        .inv_tag    (inv_asid),
        .cmp_vpn    (lk_vpn),
        .cmp_tag    (st_q.asid),
        .hit        (tbl_hit),
        .hit_ppn    (tbl_ppn),
        .hit_cached (tbl_cached)
    );

    tlb_region u_region (
        .super_mode    (lk_super),
        .vpn           (lk_vpn),
        .bypass        (seg_bypass),
        .bypass_cached (seg_cached),
        .bypass_ppn    (seg_ppn),
        .addr_err      (seg_err)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rsp = '0;
        if (asid_we) begin
            st_d.asid = asid_wdata;
        end
        if (lk_req) begin
            st_d.rsp.valid = 1'b1;
            if (seg_err) begin
                st_d.rsp.addr_err = 1'b1;
            end else if (seg_bypass) begin
                st_d.rsp.hit    = 1'b1;
                st_d.rsp.ppn    = seg_ppn;
                st_d.rsp.cached = seg_cached;
            end else if (tbl_hit) begin
                st_d.rsp.hit    = 1'b1;
                st_d.rsp.ppn    = tbl_ppn;
                st_d.rsp.cached = tbl_cached;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.rsp.valid;
    assign rsp_hit      = st_q.rsp.hit;
    assign rsp_addr_err = st_q.rsp.addr_err;
    assign rsp_ppn      = st_q.rsp.ppn;
    assign rsp_cached   = st_q.rsp.cached;
endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk
    import ttlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             lk_super,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             wired_we,
    input logic [IDX_W-1:0] wired_wdata,
    input logic [IDX_W-1:0] wired_idx,
    input logic [IDX_W-1:0] random_idx,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_addr_err,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic             rsp_cached
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

    // R6
    rnd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        random_idx >= wired_idx);

    // R6
    rnd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wired_we && (random_idx > wired_idx)) |=> (random_idx == $past(random_idx) - 1'b1));

    // R6
    rnd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wired_we && (random_idx == wired_idx)) |=> (random_idx == TOP_IDX));

    // R7
    wired_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wired_we |=> ((random_idx == TOP_IDX) && (wired_idx == $past(wired_wdata))));

    // R1
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_addr_err));

    // R9
    user_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_super && lk_vpn[VPN_W-1]) |=> (rsp_addr_err && !rsp_hit));

    // R8
    direct_cached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_super && (lk_vpn[VPN_W-1 -: REGION_W] == SEG_DIRECT_CACHED))
        |=> (rsp_hit && rsp_cached && (rsp_ppn == PPN_W'($past(lk_vpn[WIN_W-1:0])))));

    // R8
    direct_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_super && (lk_vpn[VPN_W-1 -: REGION_W] == SEG_DIRECT_UNCACHED))
        |=> (rsp_hit && !rsp_cached && (rsp_ppn == PPN_W'($past(lk_vpn[WIN_W-1:0])))));
endmodule

bind tagged_tlb tagged_tlb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_req       (lk_req),
    .lk_super     (lk_super),
    .lk_vpn       (lk_vpn),
    .wired_we     (wired_we),
    .wired_wdata  (wired_wdata),
    .wired_idx    (wired_idx),
    .random_idx   (random_idx),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_addr_err (rsp_addr_err),
    .rsp_ppn      (rsp_ppn),
    .rsp_cached   (rsp_cached)
);

// File: tb/tagged_tlb_test.sv
module tagged_tlb_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int N          = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req, lk_super;
    logic [19:0] lk_vpn;
    logic        asid_we;
    logic [7:0]  asid_wdata;
    logic        wired_we;
    logic [3:0]  wired_wdata;
    logic        fill_we, fill_use_random;
    logic [3:0]  fill_index;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic        fill_global;
    logic [19:0] fill_ppn;
    logic        fill_cached;
    logic        inv_req;
    logic [7:0]  inv_asid;
    logic [3:0]  random_idx;
    logic        rsp_valid, rsp_hit, rsp_addr_err, rsp_cached;
    logic [19:0] rsp_ppn;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tagged_tlb uut (.*);

    // bench model
    logic        m_valid [N];
    logic        m_glob  [N];
    logic [7:0]  m_tag   [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];
    logic        m_cach  [N];
    logic [7:0]  m_cur;
    logic [3:0]  m_wired, m_rand;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R12";

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic clear_inputs();
        lk_req = 0; lk_super = 0; lk_vpn = '0;
        asid_we = 0; asid_wdata = '0;
        wired_we = 0; wired_wdata = '0;
        fill_we = 0; fill_use_random = 0; fill_index = '0;
        fill_vpn = '0; fill_asid = '0; fill_global = 0; fill_ppn = '0; fill_cached = 0;
        inv_req = 0; inv_asid = '0;
    endtask

    // expected lookup from the pre-edge model state
    task automatic expect_rsp(output logic v, output logic h, output logic e,
                              output logic [19:0] p, output logic c);
        v = 0; h = 0; e = 0; p = '0; c = 0;
        if (lk_req) begin
            v = 1;
            if (!lk_super && lk_vpn[19]) e = 1;
            else if (lk_super && (lk_vpn[19:17] == 3'b100 || lk_vpn[19:17] == 3'b101)) begin
                h = 1; p = {3'b000, lk_vpn[16:0]}; c = (lk_vpn[19:17] == 3'b100);
            end else begin
                for (int i = N - 1; i >= 0; i--) begin
                    if (m_valid[i] && m_vpn[i] == lk_vpn && (m_glob[i] || m_tag[i] == m_cur)) begin
                        h = 1; p = m_ppn[i]; c = m_cach[i];
                    end
                end
            end
        end
    endtask

    task automatic step();
        logic ev, eh, ee, ec;
        logic [19:0] ep;
        logic [3:0] widx;
        expect_rsp(ev, eh, ee, ep, ec);
        widx = fill_use_random ? m_rand : fill_index;
        if (inv_req)
            for (int i = 0; i < N; i++)
                if (!m_glob[i] && m_tag[i] == inv_asid) m_valid[i] = 0;
        if (fill_we) begin
            m_valid[widx] = 1; m_glob[widx] = fill_global; m_tag[widx] = fill_asid;
            m_vpn[widx] = fill_vpn; m_ppn[widx] = fill_ppn; m_cach[widx] = fill_cached;
        end
        if (asid_we) m_cur = asid_wdata;
        if (wired_we) begin m_wired = wired_wdata; m_rand = 4'd15; end
        else if (m_rand <= m_wired) m_rand = 4'd15;
        else m_rand = m_rand - 4'd1;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if ({rsp_valid, rsp_hit, rsp_addr_err, rsp_ppn, rsp_cached} !== {ev, eh, ee, ep, ec}) begin
            failures++;
            $display("FAIL %s rsp actual v=%0b h=%0b e=%0b ppn=%h c=%0b expected v=%0b h=%0b e=%0b ppn=%h c=%0b",
                     cur_req, rsp_valid, rsp_hit, rsp_addr_err, rsp_ppn, rsp_cached, ev, eh, ee, ep, ec);
        end
        checks++;
        if (random_idx !== m_rand) begin
            failures++;
            $display("FAIL R6 random_idx actual=%0d expected=%0d", random_idx, m_rand);
        end
        clear_inputs();
    endtask

    task automatic lookup(input logic [19:0] v, input logic sup);
        lk_req = 1; lk_vpn = v; lk_super = sup; step();
        step(); // consume response cycle
    endtask

    task automatic set_fill(input logic rnd, input logic [3:0] idx, input logic [19:0] v,
                            input logic [7:0] t, input logic g, input logic [19:0] p, input logic c);
        fill_we = 1; fill_use_random = rnd; fill_index = idx; fill_vpn = v;
        fill_asid = t; fill_global = g; fill_ppn = p; fill_cached = c;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        clear_inputs();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_glob[i] = 0; m_tag[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_cach[i] = 0;
        end
        m_cur = 0; m_wired = 0; m_rand = 4'd15;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        checks++;
        if (rsp_valid !== 1'b0 || random_idx !== 4'd15) begin
            failures++;
            $display("FAIL R12 reset actual v=%0b rnd=%0d expected v=0 rnd=15", rsp_valid, random_idx);
        end
        m_rand = 4'd15;
        cur_req = "R12"; lookup(20'h00000, 1); lookup(20'h00012, 0);

        // R5 explicit fill then R2 hit
        cur_req = "R5"; set_fill(0, 4'd3, 20'h00012, 8'd0, 0, 20'hABCDE, 1); step();
        cur_req = "R2"; lookup(20'h00012, 0); lookup(20'h00013, 0);

        // R3 switch tag without flush
        cur_req = "R3"; asid_we = 1; asid_wdata = 8'd5; step();
        lookup(20'h00012, 0);
        set_fill(0, 4'd4, 20'h00012, 8'd5, 0, 20'h11111, 0); step();
        lookup(20'h00012, 0);
        asid_we = 1; asid_wdata = 8'd0; step();
        lookup(20'h00012, 0);

        // R4 global entry
        cur_req = "R4"; set_fill(0, 4'd6, 20'h00040, 8'd9, 1, 20'h22222, 1); step();
        lookup(20'h00040, 0);
        asid_we = 1; asid_wdata = 8'd200; step();
        lookup(20'h00040, 1);
        asid_we = 1; asid_wdata = 8'd0; step();

        // R10 invalidate tag 0
        cur_req = "R10"; inv_req = 1; inv_asid = 8'd0; step();
        lookup(20'h00012, 0); lookup(20'h00040, 0);
        asid_we = 1; asid_wdata = 8'd5; step();
        lookup(20'h00012, 0);

        // R8 direct windows, table ignored
        cur_req = "R8"; set_fill(0, 4'd7, 20'h80123, 8'd5, 1, 20'h33333, 0); step();
        lookup(20'h80123, 1); lookup(20'hA0123, 1); lookup(20'hBFFFF, 1);

        // R9 user error, supervisor mapped upper region
        cur_req = "R9"; lookup(20'h80123, 0); lookup(20'hE0000, 0);
        set_fill(0, 4'd8, 20'hC0001, 8'd5, 0, 20'h44444, 1); step();
        lookup(20'hC0001, 1); lookup(20'hC0001, 0);

        // R11 same-cycle lookup and fill, lookup and tag switch, fill and invalidate
        cur_req = "R11";
        lk_req = 1; lk_vpn = 20'h00077; set_fill(0, 4'd9, 20'h00077, 8'd5, 0, 20'h55555, 0); step();
        lookup(20'h00077, 0);
        lk_req = 1; lk_vpn = 20'h00077; asid_we = 1; asid_wdata = 8'd6; step();
        lookup(20'h00077, 0);
        asid_we = 1; asid_wdata = 8'd5; step();
        inv_req = 1; inv_asid = 8'd5; set_fill(0, 4'd10, 20'h00088, 8'd5, 0, 20'h66666, 1); step();
        lookup(20'h00088, 0); lookup(20'h00077, 0);

        // R7 wired entries survive random fills
        cur_req = "R7";
        for (int i = 0; i < 10; i++) begin
            set_fill(0, 4'(i), 20'(32'h100 + i), 8'd5, 0, 20'(32'h700 + i), 1); step();
        end
        wired_we = 1; wired_wdata = 4'd10; step();
        for (int i = 0; i < 30; i++) begin
            set_fill(1, 4'd0, 20'(32'h200 + i), 8'd5, 0, 20'(32'h900 + i), 0); step();
        end
        for (int i = 0; i < 10; i++) lookup(20'(32'h100 + i), 0);
        cur_req = "R6"; wired_we = 1; wired_wdata = 4'd15; step(); step(); step();
        wired_we = 1; wired_wdata = 4'd13; repeat (6) step();

        // random traffic
        cur_req = "R2";
        for (int n = 0; n < 4000; n++) begin
            lk_req = ($urandom_range(0, 9) < 6);
            lk_super = $urandom_range(0, 1) == 1;
            lk_vpn = {3'($urandom_range(0, 7)), 14'd0, 3'($urandom_range(0, 7))};
            if ($urandom_range(0, 9) < 2)
                set_fill($urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)),
                         {3'($urandom_range(0, 7)), 14'd0, 3'($urandom_range(0, 7))},
                         8'($urandom_range(0, 3)), $urandom_range(0, 7) == 0,
                         20'($urandom), $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 9) == 0) begin asid_we = 1; asid_wdata = 8'($urandom_range(0, 3)); end
            if ($urandom_range(0, 49) == 0) begin wired_we = 1; wired_wdata = 4'($urandom_range(0, 15)); end
            if ($urandom_range(0, 39) == 0) begin inv_req = 1; inv_asid = 8'($urandom_range(0, 3)); end
            step();
        end
        summary();
        $finish;
    end
endmodule